// File: doc/BRIEF.md
# VLAN Membership Table Command Engine

This block keeps a small table of VLAN entries, each holding a valid flag, a 12-bit VLAN identifier, a 10-bit port member mask, a 3-bit priority and a priority-enable flag. Software does not write table slots directly. Instead it writes a member mask into a data word, then writes an opcode into a command word with the go/busy bit set. The engine walks the table one slot per clock, applies the operation, and drops busy when it is done. Software polls busy before it issues the next command.

Five operations exist: do nothing, clear every entry, install an entry, drop the entry with a given VLAN identifier, and remove one port from the member mask of every entry. An install reuses the slot that already holds the same identifier. Otherwise it takes the lowest free slot. If there is neither, it raises a full flag and leaves the table alone.

A separate lookup port serves the forwarding path. It compares a presented identifier against every valid entry in parallel and returns the member mask and priority in the same cycle.

Top module: `vlan_cmd_engine`

## Requirements
- R1: After reset the command word (address 0) and data word (address 1) both read 0, busy and full are 0, and every lookup misses.
- R2: A command write with bit 3 set while idle starts an operation, and bit 3 then reads 1. Opcodes 1 (clear all), 2 (install), 3 (drop) and 4 (remove port) keep busy at 1 for exactly ENTRIES+1 cycles (17 by default). Opcode 0 and the unused opcodes 5, 6 and 7 keep busy at 1 for exactly one cycle and change nothing in the table.
- R3: While busy reads 1, writes to either word are ignored: the stored fields, the data word and the running operation are unchanged. A command write with bit 3 clear updates the stored fields and starts nothing.
- R4: An install (opcode 2) whose identifier matches no valid entry stores the data mask (data bits [9:0]), the identifier (command bits [27:16]), the priority (command bits [30:28]) and the priority enable (command bit 31) into a free slot and marks it valid. A slot freed by a drop is reused.
- R5: An install whose identifier matches a valid entry overwrites that entry's mask and priority fields and takes no further slot.
- R6: An install that finds no match and no free slot sets the full flag (command bit 4) when busy falls and leaves the table unchanged. Starting any later command clears full.
- R7: A drop (opcode 3) invalidates the entry whose identifier matches command bits [27:16] and leaves all other entries intact.
- R8: A clear-all (opcode 1) invalidates every entry, so every lookup misses once busy has fallen.
- R9: A remove-port (opcode 4) clears member bit N, where N is command bits [11:8], in every entry and leaves valid flags unchanged. A port number of 10 or more changes nothing.
- R10: The lookup port reports a hit in the same cycle when a valid entry carries the presented identifier and returns that entry's mask, priority and priority enable. On a miss all of these read 0.
- R11: The command word reads back opcode [2:0], busy [3], full [4], port [11:8], identifier [27:16], priority [30:28] and priority enable [31], with the other bits 0. The data word reads back mask [9:0] and its valid flag [11], with the other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Word address: 0 command, 1 data |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for the addressed word (combinational) |
| lk_vid | input | 12 | VLAN identifier presented for lookup |
| lk_hit | output | 1 | A valid entry matches lk_vid |
| lk_members | output | 10 | Member mask of the matching entry |
| lk_prio | output | 3 | Priority of the matching entry |
| lk_prio_en | output | 1 | Priority enable of the matching entry |

## Verification
A corrupted scan index or a wrong slot choice appears at the lookup port as soon as busy falls. Depending on the fault, a hit vanishes, a stale mask survives, or a duplicate identifier takes a second slot and sets full too early. A stuck sequencer state appears within ENTRIES+1 cycles as a busy count that is off. The bench therefore compares every operation's busy length against the opcode. After each command completes, it checks lookups over a small identifier pool against a reference model. That pool is small enough that install collisions, full tables and slot reuse happen often.

// File: rtl/vlan_cmd_pkg.sv
package vlan_cmd_pkg;

    localparam int VID_W  = 12;
    localparam int MBR_W  = 10;
    localparam int PRIO_W = 3;
    localparam int PORT_W = 4;
    localparam int OP_W   = 3;

    // command word layout
    localparam int OP_LSB    = 0;
    localparam int BUSY_BIT  = 3;
    localparam int FULL_BIT  = 4;
    localparam int PORT_LSB  = 8;
    localparam int VID_LSB   = 16;
    localparam int PRIO_LSB  = 28;
    localparam int PEN_BIT   = 31;
    // data word layout
    localparam int MBR_LSB   = 0;
    localparam int DVAL_BIT  = 11;

    localparam logic [OP_W-1:0] OP_NOP    = 3'd0;
    localparam logic [OP_W-1:0] OP_CLEAR  = 3'd1;
    localparam logic [OP_W-1:0] OP_LOAD   = 3'd2;
    localparam logic [OP_W-1:0] OP_DROP   = 3'd3;
    localparam logic [OP_W-1:0] OP_RMPORT = 3'd4;

    typedef struct packed {
        logic              valid;
        logic [VID_W-1:0]  vid;
        logic [MBR_W-1:0]  members;
        logic [PRIO_W-1:0] prio;
        logic              prio_en;
    } vt_entry_t;

    typedef struct packed {
        logic [OP_W-1:0]   op;
        logic [PORT_W-1:0] port;
        logic [VID_W-1:0]  vid;
        logic [PRIO_W-1:0] prio;
        logic              prio_en;
    } cmd_fields_t;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_SCAN   = 2'd1,
        SEQ_FINISH = 2'd2
    } seq_state_e;

endpackage

// File: rtl/vlan_tbl_store.sv
module vlan_tbl_store
    import vlan_cmd_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  vt_entry_t                  wr_entry,
    input  logic [IDX_W-1:0]           rd_idx,
    output vt_entry_t                  rd_entry,
    output vt_entry_t [ENTRIES-1:0]    entries_o
);

    vt_entry_t [ENTRIES-1:0] tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en) begin
            tbl_d[wr_idx] = wr_entry;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign rd_entry  = tbl_q[rd_idx];
    assign entries_o = tbl_q;

endmodule

// File: rtl/vlan_lookup.sv
module vlan_lookup
    import vlan_cmd_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  vt_entry_t [ENTRIES-1:0] entries_i,
    input  logic [VID_W-1:0]        key_vid,
    output logic                    hit,
    output logic [MBR_W-1:0]        members,
    output logic [PRIO_W-1:0]       prio,
    output logic                    prio_en
);

    logic [ENTRIES-1:0] match;
    vt_entry_t          sel;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = entries_i[g].valid && (entries_i[g].vid == key_vid);
    end

    // lowest matching slot wins
    always_comb begin
        sel = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                sel = entries_i[i];
            end
        end
    end

    assign hit     = |match;
    assign members = hit ? sel.members : '0;
    assign prio    = hit ? sel.prio    : '0;
    assign prio_en = hit && sel.prio_en;

endmodule

// File: rtl/vlan_cmd_seq.sv
module vlan_cmd_seq
    import vlan_cmd_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int ADDR_W  = 2,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [IDX_W-1:0]  rd_idx,
    input  vt_entry_t         rd_entry,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output vt_entry_t         wr_entry,
    output logic              busy_o,
    output logic              full_o,
    output logic [31:0]       cmd_word_o
);

    localparam logic [ADDR_W-1:0] CMD_ADDR  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'(1);
    localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(ENTRIES - 1);

    typedef struct packed {
        seq_state_e        st;
        logic [IDX_W-1:0]  idx;
        cmd_fields_t       cmd;
        logic              full;
        logic [MBR_W-1:0]  dmask;
        logic              dvalid;
        logic              hit;
        logic [IDX_W-1:0]  hit_idx;
        logic              free;
        logic [IDX_W-1:0]  free_idx;
    } seq_t;

    seq_t s_d, s_q;

    logic             cmd_wr, dat_wr, go_bit, scan_op, vid_eq;
    logic [MBR_W-1:0] port_clr;
    vt_entry_t        new_entry;
    logic [31:0]      cmd_word, data_word;
    logic             unused_wbits;

    assign cmd_wr  = bus_we && (bus_addr == CMD_ADDR);
    assign dat_wr  = bus_we && (bus_addr == DATA_ADDR);
    assign go_bit  = bus_wdata[BUSY_BIT];
    assign scan_op = (bus_wdata[OP_LSB +: OP_W] == OP_CLEAR)  ||
                     (bus_wdata[OP_LSB +: OP_W] == OP_LOAD)   ||
                     (bus_wdata[OP_LSB +: OP_W] == OP_DROP)   ||
                     (bus_wdata[OP_LSB +: OP_W] == OP_RMPORT);
    assign vid_eq  = rd_entry.valid && (rd_entry.vid == s_q.cmd.vid);
    assign unused_wbits = ^{bus_wdata[15:12], bus_wdata[7:5]};

    // one-hot member bit selected by the port field; ports past the mask select nothing
    always_comb begin
        for (int b = 0; b < MBR_W; b++) begin
            port_clr[b] = (s_q.cmd.port == PORT_W'(b));
        end
    end

    always_comb begin
        new_entry         = '0;
        new_entry.valid   = 1'b1;
        new_entry.vid     = s_q.cmd.vid;
        new_entry.members = s_q.dmask;
        new_entry.prio    = s_q.cmd.prio;
        new_entry.prio_en = s_q.cmd.prio_en;
    end

    always_comb begin
        s_d      = s_q;
        wr_en    = 1'b0;
        wr_idx   = s_q.idx;
        wr_entry = rd_entry;
        unique case (s_q.st)
            SEQ_IDLE: begin
                if (dat_wr) begin
                    s_d.dmask  = bus_wdata[MBR_LSB +: MBR_W];
                    s_d.dvalid = bus_wdata[DVAL_BIT];
                end
                if (cmd_wr) begin
                    s_d.cmd.op      = bus_wdata[OP_LSB +: OP_W];
                    s_d.cmd.port    = bus_wdata[PORT_LSB +: PORT_W];
                    s_d.cmd.vid     = bus_wdata[VID_LSB +: VID_W];
                    s_d.cmd.prio    = bus_wdata[PRIO_LSB +: PRIO_W];
                    s_d.cmd.prio_en = bus_wdata[PEN_BIT];
                    if (go_bit) begin
                        s_d.full     = 1'b0;
                        s_d.idx      = '0;
                        s_d.hit      = 1'b0;
                        s_d.hit_idx  = '0;
                        s_d.free     = 1'b0;
                        s_d.free_idx = '0;
                        s_d.st       = scan_op ? SEQ_SCAN : SEQ_FINISH;
                    end
                end
            end
            SEQ_SCAN: begin
                case (s_q.cmd.op)
                    OP_CLEAR: begin
                        wr_en          = 1'b1;
                        wr_entry.valid = 1'b0;
                    end
                    OP_DROP: begin
                        if (vid_eq) begin
                            wr_en          = 1'b1;
                            wr_entry.valid = 1'b0;
                        end
                    end
                    OP_RMPORT: begin
                        if (|(rd_entry.members & port_clr)) begin
                            wr_en            = 1'b1;
                            wr_entry.members = rd_entry.members & ~port_clr;
                        end
                    end
                    OP_LOAD: begin
                        if (vid_eq && !s_q.hit) begin
                            s_d.hit     = 1'b1;
                            s_d.hit_idx = s_q.idx;
                        end
                        if (!rd_entry.valid && !s_q.free) begin
                            s_d.free     = 1'b1;
                            s_d.free_idx = s_q.idx;
                        end
                    end
                    default: ;
                endcase
                s_d.idx = s_q.idx + 1'b1;
                if (s_q.idx == LAST_IDX) begin
                    s_d.st = SEQ_FINISH;
                end
            end
            SEQ_FINISH: begin
                if (s_q.cmd.op == OP_LOAD) begin
                    if (s_q.hit) begin
                        wr_en    = 1'b1;
                        wr_idx   = s_q.hit_idx;
                        wr_entry = new_entry;
                    end else if (s_q.free) begin
                        wr_en    = 1'b1;
                        wr_idx   = s_q.free_idx;
                        wr_entry = new_entry;
                    end else begin
                        s_d.full = 1'b1;
                    end
                end
                s_d.st = SEQ_IDLE;
            end
            default: s_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: SEQ_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_idx = s_q.idx;
    assign busy_o = (s_q.st != SEQ_IDLE);
    assign full_o = s_q.full;

    always_comb begin
        cmd_word                        = '0;
        cmd_word[OP_LSB +: OP_W]        = s_q.cmd.op;
        cmd_word[BUSY_BIT]              = busy_o;
        cmd_word[FULL_BIT]              = s_q.full;
        cmd_word[PORT_LSB +: PORT_W]    = s_q.cmd.port;
        cmd_word[VID_LSB +: VID_W]      = s_q.cmd.vid;
        cmd_word[PRIO_LSB +: PRIO_W]    = s_q.cmd.prio;
        cmd_word[PEN_BIT]               = s_q.cmd.prio_en;
        data_word                       = '0;
        data_word[MBR_LSB +: MBR_W]     = s_q.dmask;
        data_word[DVAL_BIT]             = s_q.dvalid;
    end

    assign cmd_word_o = cmd_word;
    assign bus_rdata  = (bus_addr == CMD_ADDR)  ? cmd_word  :
                        (bus_addr == DATA_ADDR) ? data_word : 32'd0;

endmodule

// File: rtl/vlan_cmd_engine.sv
module vlan_cmd_engine
    import vlan_cmd_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int ADDR_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [11:0]       lk_vid,
    output logic              lk_hit,
    output logic [9:0]        lk_members,
    output logic [2:0]        lk_prio,
    output logic              lk_prio_en
);

    localparam int IDX_W = $clog2(ENTRIES);

    logic [IDX_W-1:0]        rd_idx, wr_idx;
    vt_entry_t               rd_entry, wr_entry;
    logic                    wr_en;
    vt_entry_t [ENTRIES-1:0] entries;
    logic                    seq_busy, seq_full;
    logic [31:0]             seq_cmd_word;

    vlan_cmd_seq #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .rd_idx     (rd_idx),
        .rd_entry   (rd_entry),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_entry   (wr_entry),
        .busy_o     (seq_busy),
        .full_o     (seq_full),
        .cmd_word_o (seq_cmd_word)
    );

    vlan_tbl_store #(.ENTRIES(ENTRIES)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_entry  (wr_entry),
        .rd_idx    (rd_idx),
        .rd_entry  (rd_entry),
        .entries_o (entries)
    );

    vlan_lookup #(.ENTRIES(ENTRIES)) u_lookup (
        .entries_i (entries),
        .key_vid   (lk_vid),
        .hit       (lk_hit),
        .members   (lk_members),
        .prio      (lk_prio),
        .prio_en   (lk_prio_en)
    );

endmodule

// File: rtl/vlan_cmd_engine_chk.sv
module vlan_cmd_engine_chk #(
    parameter int ENTRIES = 16,
    parameter int ADDR_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [3:0]        wlow,
    input logic              busy,
    input logic              full,
    input logic [31:0]       cmd_word,
    input logic              lk_hit,
    input logic [9:0]        lk_members,
    input logic [2:0]        lk_prio,
    input logic              lk_prio_en
);

    localparam int CNT_W = $clog2(ENTRIES + 2) + 1;

    logic [CNT_W-1:0] busy_cnt;
    logic             start_wr, short_op;

    assign start_wr = bus_we && (bus_addr == '0) && wlow[3] && !busy;
    assign short_op = (wlow[2:0] == 3'd0) || (wlow[2:0] > 3'd4);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt <= '0;
        end else if (busy) begin
            busy_cnt <= busy_cnt + 1'b1;
        end else begin
            busy_cnt <= '0;
        end
    end

    // R2
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_cnt <= CNT_W'(ENTRIES)));

    // R2
    short_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_wr && short_op) |=> busy ##1 !busy);

    // R3
    busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_we && (bus_addr == '0)) |=> ($stable(cmd_word[27:16]) && $stable(cmd_word[2:0])));

    // R6
    full_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full) |-> $fell(busy));

    // R6
    full_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_wr |=> !full);

    // R8
    clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && (cmd_word[2:0] == 3'd1)) |-> !lk_hit);

    // R10
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> ((lk_members == '0) && (lk_prio == '0) && !lk_prio_en));

endmodule

bind vlan_cmd_engine vlan_cmd_engine_chk #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .wlow       (bus_wdata[3:0]),
    .busy       (seq_busy),
    .full       (seq_full),
    .cmd_word   (seq_cmd_word),
    .lk_hit     (lk_hit),
    .lk_members (lk_members),
    .lk_prio    (lk_prio),
    .lk_prio_en (lk_prio_en)
);

// File: tb/vlan_cmd_engine_bench.sv
`timescale 1ns/1ps
module vlan_cmd_engine_bench;

    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [11:0] lk_vid = '0;
    logic        lk_hit;
    logic [9:0]  lk_members;
    logic [2:0]  lk_prio;
    logic        lk_prio_en;

    int n_tests = 0;
    int n_fail  = 0;

    // reference model
    logic        m_valid [N];
    logic [11:0] m_vid   [N];
    logic [9:0]  m_mbr   [N];
    logic [2:0]  m_prio  [N];
    logic        m_pen   [N];
    logic        m_full;
    logic [9:0]  m_dmask;
    logic        m_dval;

    always #2.5 clk = ~clk;

    vlan_cmd_engine u_vlan_cmd_engine (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lk_vid(lk_vid),
        .lk_hit(lk_hit), .lk_members(lk_members), .lk_prio(lk_prio),
        .lk_prio_en(lk_prio_en)
    );

    function automatic logic [31:0] mk_cmd(input logic [2:0] op, input logic go,
        input logic [3:0] port, input logic [11:0] vid, input logic [2:0] prio, input logic pen);
        return {pen, prio, vid, 4'h0, port, 3'b000, 1'b0, go, op};
    endfunction

    function automatic void m_reset();
        for (int i = 0; i < N; i++) begin
            m_valid[i] = 0; m_vid[i] = 0; m_mbr[i] = 0; m_prio[i] = 0; m_pen[i] = 0;
        end
        m_full = 0; m_dmask = 0; m_dval = 0;
    endfunction

    function automatic void m_apply(input logic [2:0] op, input logic [3:0] port,
        input logic [11:0] vid, input logic [2:0] prio, input logic pen);
        int slot;
        m_full = 0;
        case (op)
            3'd1: for (int i = 0; i < N; i++) m_valid[i] = 0;
            3'd3: for (int i = 0; i < N; i++) if (m_valid[i] && m_vid[i] == vid) m_valid[i] = 0;
            3'd4: if (port < 10) for (int i = 0; i < N; i++) m_mbr[i][port] = 1'b0;
            3'd2: begin
                slot = -1;
                for (int i = 0; i < N; i++) if (slot < 0 && m_valid[i] && m_vid[i] == vid) slot = i;
                if (slot < 0) for (int i = 0; i < N; i++) if (slot < 0 && !m_valid[i]) slot = i;
                if (slot < 0) m_full = 1;
                else begin
                    m_valid[slot] = 1; m_vid[slot] = vid; m_mbr[slot] = m_dmask;
                    m_prio[slot] = prio; m_pen[slot] = pen;
                end
            end
            default: ;
        endcase
    endfunction

    function automatic logic [31:0] m_lookup(input logic [11:0] vid);
        for (int i = 0; i < N; i++)
            if (m_valid[i] && m_vid[i] == vid) return {17'd0, 1'b1, m_mbr[i], m_prio[i], m_pen[i]};
        return 32'd0;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic read_word(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_idle(output int cnt);
        bus_addr = 2'd0;
        #1;
        cnt = 0;
        while (bus_rdata[3] && cnt < 100) begin
            cnt++;
            @(negedge clk);
            #1;
        end
    endtask

    task automatic set_data(input logic [9:0] mask, input logic val);
        bus_write(2'd1, {20'd0, val, 1'b0, mask});
        m_dmask = mask; m_dval = val;
    endtask

    task automatic do_op(input logic [2:0] op, input logic [3:0] port, input logic [11:0] vid,
        input logic [2:0] prio, input logic pen, input string tag);
        int cyc;
        int exp_cyc;
        bus_write(2'd0, mk_cmd(op, 1'b1, port, vid, prio, pen));
        wait_idle(cyc);
        exp_cyc = (op >= 3'd1 && op <= 3'd4) ? N + 1 : 1;
        chk(cyc == exp_cyc, {"R2 busy length ", tag}, cyc, exp_cyc);
        m_apply(op, port, vid, prio, pen);
    endtask

    task automatic check_lookup(input logic [11:0] vid, input string tag);
        logic [31:0] act, exp;
        @(negedge clk);
        lk_vid = vid;
        #1;
        act = {17'd0, lk_hit, lk_members, lk_prio, lk_prio_en};
        exp = m_lookup(vid);
        chk(act == exp, {"R10 lookup ", tag}, act, exp);
    endtask

    task automatic check_full(input string tag);
        logic [31:0] w;
        read_word(2'd0, w);
        chk(w[4] == m_full, {"R6 full flag ", tag}, {31'd0, w[4]}, {31'd0, m_full});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R2 watchdog expired actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] w;
        int cyc;
        void'($urandom(32'd4242));
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        read_word(2'd0, w); chk(w == 32'd0, "R1 cmd word after reset", w, 32'd0);
        read_word(2'd1, w); chk(w == 32'd0, "R1 data word after reset", w, 32'd0);
        check_lookup(12'h000, "R1 reset miss vid0");
        check_lookup(12'h123, "R1 reset miss");

        // R11 data readback layout
        bus_write(2'd1, 32'hFFFF_FBFF);
        read_word(2'd1, w); chk(w == 32'h0000_0BFF, "R11 data readback", w, 32'h0000_0BFF);
        m_dmask = 10'h3FF; m_dval = 1;

        // R3 command write without go bit: fields stored, nothing starts
        bus_write(2'd0, {1'b1, 3'd5, 12'h123, 4'hF, 4'd5, 3'b111, 1'b1, 1'b0, 3'd2});
        read_word(2'd0, w);
        chk(w == 32'hD123_0502, "R11 R3 cmd readback without go", w, 32'hD123_0502);
        check_lookup(12'h123, "R3 no start without go");

        // R4 install
        set_data(10'h155, 1'b1);
        do_op(3'd2, 4'd0, 12'h123, 3'd5, 1'b1, "install");
        check_lookup(12'h123, "R4 installed entry");
        check_full("R4 no full");

        // R5 overwrite
        set_data(10'h0AA, 1'b0);
        do_op(3'd2, 4'd0, 12'h123, 3'd2, 1'b0, "overwrite");
        check_lookup(12'h123, "R5 overwritten entry");

        // R6 fill table, then overflow
        for (int i = 0; i < N - 1; i++) begin
            set_data(10'(i * 37 + 1), 1'b1);
            do_op(3'd2, 4'd0, 12'(12'h200 + i), 3'(i), 1'(i), "fill");
        end
        check_full("R5 after fill, no full");
        check_lookup(12'h123, "R5 overwrite took no slot");
        set_data(10'h3C3, 1'b1);
        do_op(3'd2, 4'd0, 12'h300, 3'd7, 1'b1, "overflow");
        check_full("R6 set on overflow");
        chk(m_full == 1'b1, "R6 model full", {31'd0, m_full}, 32'd1);
        check_lookup(12'h300, "R6 table unchanged miss");
        check_lookup(12'h20E, "R6 table unchanged hit");
        do_op(3'd2, 4'd0, 12'h205, 3'd1, 1'b1, "overwrite when full");
        check_full("R6 cleared by next command");
        check_lookup(12'h205, "R5 overwrite on full table");

        // R7 drop, then slot reuse
        do_op(3'd3, 4'd0, 12'h205, 3'd0, 1'b0, "drop");
        check_lookup(12'h205, "R7 dropped");
        check_lookup(12'h204, "R7 neighbour kept");
        check_lookup(12'h206, "R7 neighbour kept");
        do_op(3'd2, 4'd0, 12'h300, 3'd7, 1'b1, "reuse");
        check_lookup(12'h300, "R4 slot reused");
        check_full("R4 reuse no full");

        // R9 remove port
        do_op(3'd4, 4'd3, 12'h000, 3'd0, 1'b0, "rmport3");
        for (int i = 0; i < 6; i++) check_lookup(12'(12'h200 + i), "R9 port 3 removed");
        check_lookup(12'h300, "R9 port 3 removed");
        do_op(3'd4, 4'd12, 12'h000, 3'd0, 1'b0, "rmport12");
        check_lookup(12'h300, "R9 port 12 no effect");
        check_lookup(12'h123, "R9 port 12 no effect");

        // R3 writes while busy ignored
        set_data(10'h0F0, 1'b1);
        bus_write(2'd0, mk_cmd(3'd2, 1'b1, 4'd0, 12'h123, 3'd6, 1'b1));
        bus_write(2'd0, mk_cmd(3'd1, 1'b1, 4'd2, 12'h777, 3'd0, 1'b0));
        bus_write(2'd1, 32'h0000_03FF);
        wait_idle(cyc);
        m_apply(3'd2, 4'd0, 12'h123, 3'd6, 1'b1);
        read_word(2'd0, w);
        chk(w == mk_cmd(3'd2, 1'b0, 4'd0, 12'h123, 3'd6, 1'b1), "R3 cmd fields kept while busy",
            w, mk_cmd(3'd2, 1'b0, 4'd0, 12'h123, 3'd6, 1'b1));
        read_word(2'd1, w); chk(w == 32'h0000_08F0, "R3 data kept while busy", w, 32'h0000_08F0);
        check_lookup(12'h123, "R3 install completed");
        check_lookup(12'h300, "R3 clear not run");

        // R2 unused opcode
        do_op(3'd5, 4'd1, 12'h123, 3'd0, 1'b0, "opcode5");
        check_lookup(12'h123, "R2 opcode5 no change");
        do_op(3'd0, 4'd1, 12'h300, 3'd0, 1'b0, "nop");
        check_lookup(12'h300, "R2 nop no change");

        // R8 clear all
        do_op(3'd1, 4'd0, 12'h000, 3'd0, 1'b0, "clear");
        for (int v = 0; v < 4; v++) check_lookup(12'(12'h200 + v), "R8 cleared");
        check_lookup(12'h123, "R8 cleared");

        // random mix
        for (int it = 0; it < 400; it++) begin
            int r;
            logic [11:0] vid;
            r = int'($urandom % 20);
            vid = 12'(12'h040 + ($urandom % 24));
            if (r < 3) set_data(10'($urandom), 1'($urandom));
            else if (r < 11) do_op(3'd2, 4'd0, vid, 3'($urandom), 1'($urandom), "rand install");
            else if (r < 15) do_op(3'd3, 4'd0, vid, 3'd0, 1'b0, "rand drop");
            else if (r < 17) do_op(3'd4, 4'($urandom % 12), 12'd0, 3'd0, 1'b0, "rand rmport");
            else if (r < 19) do_op(3'($urandom % 8 == 0 ? 0 : 5 + ($urandom % 3)), 4'd0, vid, 3'd0, 1'b0, "rand short");
            else do_op(3'd1, 4'd0, 12'd0, 3'd0, 1'b0, "rand clear");
            check_full("R6 random");
            for (int k = 0; k < 3; k++) check_lookup(12'(12'h040 + ($urandom % 24)), "R4 R5 R7 R9 random");
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule